// File: doc/BRIEF.md
# I2C Interrupt Vector Encoder

This block gathers the event pulses that an I2C bus engine produces (arbitration lost, no-acknowledge, access ready, receive ready, transmit ready, stop seen, addressed as a target) into sticky flags. Each flag is gated by an enable bit. The lowest-numbered pending enabled event is presented as a small numeric code in a vector register, and one interrupt line goes high whenever any enabled flag is pending.

Software uses a plain register port. It writes the enable register. It reads the status register to see every raw flag plus two live bus-state bits, and writes ones there to clear flags. It can also read the vector register repeatedly. Each vector read reports one event and clears only that flag, so a service loop runs until the read returns zero. The register port is a control path with no back-pressure: a read strobe always returns data one cycle later, and a write strobe always takes effect at the clock edge where it is sampled.

Top module: `i2c_irq_vector`

## Requirements
- R1: After reset the enable register and all flags are zero, the interrupt line is low and read data is zero.
- R2: A one on event input bit i sets status flag i, and the flag stays set until it is cleared. The bit order is 0 arbitration lost, 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop seen, 6 addressed as target.
- R3: Status bit 12 shows the bus-busy input and status bit 11 shows the receive-shift-full input. Neither bit ever produces a vector code or raises the interrupt.
- R4: A vector read (address 2) returns code i+1 for the lowest-indexed flag that is both pending and enabled, so arbitration lost (code 1) wins over all others. It returns 0 when no enabled flag is pending.
- R5: A vector read clears only the flag it reports. A vector read that returns 0 changes no flag.
- R6: A flag whose enable bit is zero still shows in status, but it affects neither the vector nor the interrupt.
- R7: Writing the status register (address 1) clears every flag whose write-data bit is one and leaves flags whose bit is zero unchanged.
- R8: The interrupt line is high exactly when at least one pending flag is enabled.
- R9: An event pulse in the same cycle as a clear of the same flag, by either a status write or a vector read, leaves the flag set.
- R10: Read data appears the cycle after the read strobe. The enable register (address 0) reads back in bits 0 to 6 with zero above, and address 3 reads zero.
- R11: Reading the enable or status register changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 7 | Per-event set pulses from the bus engine |
| bus_busy_i | input | 1 | Live bus-busy level |
| rx_shift_full_i | input | 1 | Live receive-shift-full level |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select: 0 enable, 1 status, 2 vector, 3 reserved |
| wdata_i | input | 7 | Write data for the event bit positions |
| rdata_o | output | 16 | Read data, valid one cycle after the strobe |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that the interrupt agrees with the encoder producing a nonzero code, that the reported code belongs to an enabled pending flag with no enabled pending flag below it, that pulses set flags, that status writes and vector reads clear exactly their targets unless a pulse arrives in the same cycle, and that the bus-state bits read back live. Only the bench scenarios show the full service walk: seven events pending, reported one by one in priority order, and then a zero. The same is true for masking after flags are already pending, and for the reserved address and the enable readback.

// File: rtl/i2c_irqv_pkg.sv
package i2c_irqv_pkg;
  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_STAT = 2'd1,
    SEL_VEC  = 2'd2,
    SEL_RSVD = 2'd3
  } reg_sel_e;

  // event bit indices; vector code is index + 1
  localparam int EV_ARB_LOST = 0;
  localparam int EV_NO_ACK   = 1;
  localparam int EV_ACC_RDY  = 2;
  localparam int EV_RX_RDY   = 3;
  localparam int EV_TX_RDY   = 4;
  localparam int EV_STOP     = 5;
  localparam int EV_AS_TGT   = 6;
endpackage

// File: rtl/i2c_irqv_flags.sv
module i2c_irqv_flags #(
  parameter int N_EVT = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EVT-1:0] set_i,
  input  logic [N_EVT-1:0] clr_i,
  output logic [N_EVT-1:0] flag_o
);
  logic [N_EVT-1:0] flag_q;

  for (genvar g = 0; g < N_EVT; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_q[g] <= 1'b0;
      else if (set_i[g])  flag_q[g] <= 1'b1;   // set beats clear
      else if (clr_i[g])  flag_q[g] <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/i2c_irqv_prio.sv
module i2c_irqv_prio #(
  parameter int N_EVT  = 7,
  parameter int CODE_W = 3
) (
  input  logic [N_EVT-1:0]  pend_i,
  output logic [CODE_W-1:0] code_o,
  output logic [N_EVT-1:0]  hit_o
);
  always_comb begin
    code_o = '0;
    hit_o  = '0;
    for (int i = N_EVT - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        code_o = CODE_W'(i + 1);
        hit_o  = '0;
        hit_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_irqv_maskreg.sv
module i2c_irqv_maskreg #(
  parameter int N_EVT = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [N_EVT-1:0] wdata_i,
  output logic [N_EVT-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_o <= '0;
    else if (we_i) mask_o <= wdata_i;
  end
endmodule

// File: rtl/i2c_irq_vector.sv
module i2c_irq_vector
  import i2c_irqv_pkg::*;
#(
  parameter int N_EVT   = 7,
  parameter int DW      = 16,
  parameter int BB_POS  = 12,
  parameter int RSF_POS = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EVT-1:0] evt_i,
  input  logic             bus_busy_i,
  input  logic             rx_shift_full_i,
  input  logic             rd_en_i,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [N_EVT-1:0] wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             irq_o
);
  localparam int CODE_W = $clog2(N_EVT + 1);

  reg_sel_e          sel;
  logic              rd_vec, rd_any_clr;
  logic [N_EVT-1:0]  mask_q, flag_q, pend, hit_oh, clr_vec;
  logic [N_EVT-1:0]  clr_all;
  logic [CODE_W-1:0] vec_code;
  logic [DW-1:0]     rd_mux;

  assign sel    = reg_sel_e'(addr_i);
  assign rd_vec = rd_en_i && (sel == SEL_VEC);

  i2c_irqv_maskreg #(.N_EVT(N_EVT)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_en_i && (sel == SEL_MASK)),
    .wdata_i(wdata_i),
    .mask_o (mask_q)
  );

  assign pend = flag_q & mask_q;

  i2c_irqv_prio #(.N_EVT(N_EVT), .CODE_W(CODE_W)) u_prio (
    .pend_i(pend),
    .code_o(vec_code),
    .hit_o (hit_oh)
  );

  assign rd_any_clr = rd_vec;
  assign clr_vec    = rd_any_clr ? hit_oh : '0;
  assign clr_all    = clr_vec | ((wr_en_i && (sel == SEL_STAT)) ? wdata_i : '0);

  i2c_irqv_flags #(.N_EVT(N_EVT)) u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (evt_i),
    .clr_i (clr_all),
    .flag_o(flag_q)
  );

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_MASK: rd_mux[N_EVT-1:0] = mask_q;
      SEL_STAT: begin
        rd_mux[N_EVT-1:0] = flag_q;
        rd_mux[BB_POS]    = bus_busy_i;
        rd_mux[RSF_POS]   = rx_shift_full_i;
      end
      SEL_VEC:  rd_mux[CODE_W-1:0] = vec_code;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end

  assign irq_o = |pend;
endmodule

// File: rtl/i2c_irqv_chk.sv
module i2c_irqv_chk #(
  parameter int N_EVT   = 7,
  parameter int DW      = 16,
  parameter int BB_POS  = 12,
  parameter int RSF_POS = 11,
  parameter int CODE_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_EVT-1:0]  evt_i,
  input logic              bus_busy_i,
  input logic              rx_shift_full_i,
  input logic              rd_en_i,
  input logic              wr_en_i,
  input logic [1:0]        addr_i,
  input logic [N_EVT-1:0]  wdata_i,
  input logic [DW-1:0]     rdata_o,
  input logic              irq_o,
  input logic [N_EVT-1:0]  flags,
  input logic [N_EVT-1:0]  mask,
  input logic [CODE_W-1:0] code
);
  logic [N_EVT-1:0] code_oh;
  logic             rd_vec, rd_stat, wr_stat;

  always_comb begin
    code_oh = '0;
    if (code != '0) code_oh = N_EVT'(1) << (code - CODE_W'(1));
  end
  assign rd_vec  = rd_en_i && (addr_i == 2'd2);
  assign rd_stat = rd_en_i && (addr_i == 2'd1);
  assign wr_stat = wr_en_i && (addr_i == 2'd1);

  // R8
  irq_vs_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (code != '0));

  // R4
  lowest_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code != '0) |-> (((flags & mask & code_oh) != '0) &&
                      ((flags & mask & (code_oh - N_EVT'(1))) == '0)));

  // R2
  evt_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((flags & $past(evt_i)) == $past(evt_i)));

  // R5
  vec_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vec |=> ((flags & $past(code_oh)) == ($past(evt_i) & $past(code_oh))));

  // R7
  w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stat |=> ((flags & $past(wdata_i) & ~$past(evt_i)) == '0));

  // R3
  live_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stat |=> (rdata_o[BB_POS] == $past(bus_busy_i)) &&
                (rdata_o[RSF_POS] == $past(rx_shift_full_i)));
endmodule

bind i2c_irq_vector i2c_irqv_chk #(
  .N_EVT(N_EVT), .DW(DW), .BB_POS(BB_POS), .RSF_POS(RSF_POS), .CODE_W(CODE_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .bus_busy_i(bus_busy_i),
  .rx_shift_full_i(rx_shift_full_i), .rd_en_i(rd_en_i), .wr_en_i(wr_en_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o),
  .flags(flag_q), .mask(mask_q), .code(vec_code)
);

// File: tb/i2c_irq_vector_bench.sv
module i2c_irq_vector_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  evt = '0;
  logic        busy = 1'b0, rsf = 1'b0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [6:0]  wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_irq_vector u_i2c_irq_vector (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .bus_busy_i(busy),
    .rx_shift_full_i(rsf), .rd_en_i(rd_en), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference model
  int m_flags, m_mask, m_rdata, m_vec;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flags = 0; m_mask = 0; m_rdata = 0;
    end else begin
      m_vec = 0;
      for (int k = 7; k >= 1; k--)
        if (((m_flags & m_mask) >> (k - 1)) & 1) m_vec = k;
      if (rd_en) begin
        case (addr)
          2'd0: m_rdata = m_mask;
          2'd1: m_rdata = m_flags + (busy ? 4096 : 0) + (rsf ? 2048 : 0);
          2'd2: m_rdata = m_vec;
          default: m_rdata = 0;
        endcase
        if (addr == 2'd2 && m_vec != 0) m_flags = m_flags & ~(1 << (m_vec - 1));
      end
      if (wr_en && addr == 2'd1) m_flags = m_flags & ~int'(wdata);
      if (wr_en && addr == 2'd0) m_mask = int'(wdata);
      m_flags = m_flags | int'(evt);
    end
  end

  // per-cycle comparison
  always @(negedge clk) if (rst_n && !done) begin
    checks++;
    if (irq !== ((m_flags & m_mask) != 0)) begin
      fails++;
      $display("FAIL R8 irq actual=%0b expected=%0b", irq, (m_flags & m_mask) != 0);
    end
    checks++;
    if (int'(rdata) != m_rdata) begin
      fails++;
      $display("FAIL R10 rdata actual=%0h expected=%0h", rdata, m_rdata);
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [6:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, input int exp, input string tag);
    rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
    check(tag, int'(rdata), exp);
  endtask

  task automatic pulse(input logic [6:0] e);
    evt = e;
    @(negedge clk); evt = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", int'(irq), 0);
    check("R1 rdata", int'(rdata), 0);
    rd(2'd0, 0, "R1 mask");
    rd(2'd1, 0, "R1 status");
    // R10 enable readback
    wr(2'd0, 7'h7F);
    rd(2'd0, 16'h007F, "R10 mask readback");
    rd(2'd3, 0, "R10 reserved");
    // R2 / R4 / R5 / R8
    pulse(7'b000_1010);
    check("R8 irq high", int'(irq), 1);
    rd(2'd1, 16'h000A, "R2 status");
    rd(2'd1, 16'h000A, "R11 status reread");
    rd(2'd2, 2, "R4 nack first");
    rd(2'd2, 4, "R5 rx ready next");
    rd(2'd2, 0, "R4 idle");
    check("R8 irq low", int'(irq), 0);
    rd(2'd2, 0, "R5 empty read");
    // R6 masking
    wr(2'd0, 7'b010_0000);
    pulse(7'b000_0001);
    check("R6 irq masked", int'(irq), 0);
    rd(2'd2, 0, "R6 vec masked");
    rd(2'd1, 16'h0001, "R6 status shows");
    pulse(7'b010_0000);
    rd(2'd2, 6, "R6 stop code");
    rd(2'd1, 16'h0001, "R5 other flag kept");
    // R7 write-one-to-clear
    wr(2'd1, 7'b000_0000);
    rd(2'd1, 16'h0001, "R7 zero write keeps");
    wr(2'd1, 7'b000_0001);
    rd(2'd1, 0, "R7 cleared");
    // R3 live bits
    wr(2'd0, 7'h7F);
    busy = 1; rsf = 1;
    @(negedge clk);
    rd(2'd1, 16'h1800, "R3 live bits");
    rd(2'd2, 0, "R3 no code");
    check("R3 no irq", int'(irq), 0);
    busy = 0; rsf = 0;
    // R9 set beats clear
    pulse(7'b000_0100);
    evt = 7'b000_0100; wr(2'd1, 7'b000_0100); evt = '0;
    rd(2'd1, 16'h0004, "R9 w1c vs set");
    evt = 7'b000_0100; rd(2'd2, 3, "R9 vec read code"); evt = '0;
    rd(2'd1, 16'h0004, "R9 vec clear vs set");
    wr(2'd1, 7'h7F);
    // R4 full priority walk
    pulse(7'h7F);
    for (int k = 1; k <= 7; k++) rd(2'd2, k, "R4 walk");
    rd(2'd2, 0, "R4 walk end");
    // R1 reset again
    pulse(7'h7F);
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    rd(2'd1, 0, "R1 status after reset");
    rd(2'd0, 0, "R1 mask after reset");
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule